// File: doc/BRIEF.md
# Attribute-Driven Cache Read Dispatcher

This block sits in front of a small second-level cache. It serves read requests that carry a 4-bit memory-type attribute. From that attribute it picks one of three routes for each request. A read may be answered from the cache array after a tag lookup. A miss may pull the whole line from the next memory level before answering. Otherwise the read goes downstream as a single uncached access. Whichever route is taken, one response word comes back to the requester.

The block takes one request at a time. A request is accepted when `req_valid_i` and `req_ready_o` are both high. Ready stays low until the response cycle has ended. Downstream accesses use a plain request/acknowledge handshake and return one word per acknowledge. The cache is direct-mapped. Addresses are word addresses: the low bits select the word within a line, the next bits select the set, and the rest form the tag.

Top module: `cache_read_dispatch`

## Requirements
- R1: The attribute layout is bit0 bufferable, bit1 cacheable, bit2 read-allocate, bit3 write-allocate. When attr[1:0]=00, the read does no lookup and no allocation. It is served by exactly one downstream read at the request address, even if the line is present in the cache.
- R2: When attr[1:0]=01 (bufferable, not cacheable), the read is served by exactly one downstream read at the request address and is not allocated.
- R3: When attr[1]=1 and attr[3:2]=00, the read is served by exactly one downstream read and is not allocated.
- R4: A read with attr[1]=1 and either allocate bit set that hits returns the cached word and makes no downstream access. Its response cycle is the second cycle after the accept edge.
- R5: A read with attr[1]=1 and attr[2]=1 that misses fetches LINE_WORDS words. The words are requested in ascending order from the line base, and the line is installed so later reads of it hit. Each downstream request holds its address until acknowledged.
- R6: A read with attr[3:2]=10 and attr[1]=1 that misses is served by one downstream read and is not allocated.
- R7: `req_ready_o` is high only when idle. It drops on the cycle after an accept and stays low through the single-cycle response pulse, then returns high.
- R8: On a linefill, the response comes in the second cycle after the last word's acknowledge edge, once the line and its valid tag are in place. On an uncached access, the response comes in the cycle after the acknowledge edge.
- R9: The set index is addr[OFF_W+IDX_W-1:OFF_W]. A fill to a set replaces the line held there, and lines in other sets are unaffected.
- R10: After reset, ready is high, no response or downstream request is active, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Dispatcher idle and able to accept |
| req_addr_i | input | ADDR_W | Word address of the read |
| req_attr_i | input | 4 | Memory-type attribute |
| rsp_valid_o | output | 1 | Response word valid (one-cycle pulse) |
| rsp_data_o | output | DATA_W | Response word |
| mem_req_o | output | 1 | Downstream read request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Downstream word address |
| mem_ack_i | input | 1 | Downstream acknowledge, carries read data |
| mem_rdata_i | input | DATA_W | Downstream read data |

## Verification
A hit responds in the second cycle after the accept edge. An uncached read responds one cycle after its acknowledge edge, and a linefill two cycles after its last acknowledge edge. The bench records a cycle stamp at the accept, at each acknowledge and at the response. It compares the differences against those numbers. All sampling happens on falling edges, so a response one cycle early or late is reported. The memory model tags every word with an epoch value that changes on every request, so the returned data shows whether it came from the cache or from a fresh downstream read.

// File: rtl/cache_rd_pkg.sv
package cache_rd_pkg;

  localparam int ATTR_W   = 4;
  localparam int ATTR_BUF = 0;
  localparam int ATTR_CAC = 1;
  localparam int ATTR_RA  = 2;
  localparam int ATTR_WA  = 3;

  typedef enum logic [2:0] {
    CLS_STRONG,
    CLS_DEVICE,
    CLS_NOALLOC,
    CLS_WA_ONLY,
    CLS_RA
  } rd_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_FILL_RD,
    ST_BYP,
    ST_RESP
  } rd_state_e;

endpackage

// File: rtl/cache_attr_decode.sv
module cache_attr_decode
  import cache_rd_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  output rd_class_e         cls_o
);

  always_comb begin
    if (!attr_i[ATTR_CAC]) begin
      cls_o = attr_i[ATTR_BUF] ? CLS_DEVICE : CLS_STRONG;
    end else if (attr_i[ATTR_RA]) begin
      cls_o = CLS_RA;
    end else if (attr_i[ATTR_WA]) begin
      cls_o = CLS_WA_ONLY;
    end else begin
      cls_o = CLS_NOALLOC;
    end
  end

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);

  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[s] <= 1'b0;
        tag_q[s]   <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(s))) begin
        valid_q[s] <= 1'b1;
        tag_q[s]   <= wr_tag_i;
      end
    end
  end

  assign hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);

endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int ENTRIES = 1 << (IDX_W + OFF_W);

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_idx_i, wr_off_i}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{rd_idx_i, rd_off_i}];

endmodule

// File: rtl/cache_read_dispatch.sv
module cache_read_dispatch
  import cache_rd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ATTR_W-1:0] req_attr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  rd_state_e         st_q, st_d;
  rd_class_e         cls_q, cls_d, cls_in;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  fill_cnt_q, fill_cnt_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  logic              tag_hit, tag_wr, arr_wr;
  logic [DATA_W-1:0] arr_rdata;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;

  assign idx = addr_q[OFF_W +: IDX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];
  assign off = addr_q[OFF_W-1:0];

  cache_attr_decode u_decode (
    .attr_i (req_attr_i),
    .cls_o  (cls_in)
  );

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx),
    .rd_tag_i (tag),
    .hit_o    (tag_hit),
    .wr_en_i  (tag_wr),
    .wr_idx_i (idx),
    .wr_tag_i (tag)
  );

  cache_data_array #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .wr_en_i   (arr_wr),
    .wr_idx_i  (idx),
    .wr_off_i  (fill_cnt_q),
    .wr_data_i (mem_rdata_i),
    .rd_idx_i  (idx),
    .rd_off_i  (off),
    .rd_data_o (arr_rdata)
  );

  always_comb begin
    st_d       = st_q;
    cls_d      = cls_q;
    addr_d     = addr_q;
    fill_cnt_d = fill_cnt_q;
    rsp_data_d = rsp_data_q;
    tag_wr     = 1'b0;
    arr_wr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          addr_d = req_addr_i;
          cls_d  = cls_in;
          // only allocate-hinted cacheable reads consult the tags
          st_d   = (cls_in == CLS_RA || cls_in == CLS_WA_ONLY) ? ST_LOOKUP : ST_BYP;
        end
      end
      ST_LOOKUP: begin
        if (tag_hit) begin
          rsp_data_d = arr_rdata;
          st_d       = ST_RESP;
        end else if (cls_q == CLS_RA) begin
          fill_cnt_d = '0;
          st_d       = ST_FILL;
        end else begin
          st_d = ST_BYP;
        end
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          arr_wr = 1'b1;
          if (fill_cnt_q == LAST_OFF) begin
            tag_wr = 1'b1;
            st_d   = ST_FILL_RD;
          end else begin
            fill_cnt_d = fill_cnt_q + OFF_W'(1);
          end
        end
      end
      ST_FILL_RD: begin
        rsp_data_d = arr_rdata;
        st_d       = ST_RESP;
      end
      ST_BYP: begin
        if (mem_ack_i) begin
          rsp_data_d = mem_rdata_i;
          st_d       = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cls_q      <= CLS_STRONG;
      addr_q     <= '0;
      fill_cnt_q <= '0;
      rsp_data_q <= '0;
    end else begin
      st_q       <= st_d;
      cls_q      <= cls_d;
      addr_q     <= addr_d;
      fill_cnt_q <= fill_cnt_d;
      rsp_data_q <= rsp_data_d;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_data_o  = rsp_data_q;
  assign mem_req_o   = (st_q == ST_FILL) || (st_q == ST_BYP);
  assign mem_addr_o  = (st_q == ST_FILL) ? {addr_q[ADDR_W-1:OFF_W], fill_cnt_q} : addr_q;

  // R7
  accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  // R8
  fill_rd_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL_RD) |-> tag_hit);

  // R4
  hit_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && tag_hit) |=> (rsp_valid_o && !mem_req_o));

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

endmodule

// File: tb/tb_cache_read_dispatch.sv
module tb_cache_read_dispatch;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int LINE    = 4;
  localparam int MEM_LAT = 2;

  typedef struct packed {
    logic [3:0]  attr;
    logic [15:0] addr;
    logic [15:0] ep;
    logic [15:0] exp_ep;
    logic [1:0]  kind;   // 0 hit, 1 uncached, 2 linefill
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{4'b0000, 16'h0040, 16'd1,  16'd1,  2'd1},  // R1 strongly ordered
    '{4'b0110, 16'h0041, 16'd2,  16'd2,  2'd2},  // R5 fill set 0
    '{4'b0110, 16'h0043, 16'd3,  16'd2,  2'd0},  // R4 hit
    '{4'b0000, 16'h0042, 16'd4,  16'd4,  2'd1},  // R1 bypass although cached
    '{4'b0001, 16'h0042, 16'd5,  16'd5,  2'd1},  // R2 device
    '{4'b0011, 16'h0040, 16'd6,  16'd6,  2'd1},  // R3 no allocate hint
    '{4'b1010, 16'h0040, 16'd7,  16'd2,  2'd0},  // R4 write-allocate only, hit
    '{4'b1010, 16'h0084, 16'd8,  16'd8,  2'd1},  // R6 write-allocate only, miss
    '{4'b1110, 16'h0084, 16'd9,  16'd9,  2'd2},  // R6 not allocated before, R5 fill set 1
    '{4'b0111, 16'h0086, 16'd10, 16'd9,  2'd0},  // R4 hit
    '{4'b0110, 16'h0240, 16'd11, 16'd11, 2'd2},  // R9 conflict in set 0
    '{4'b0110, 16'h0041, 16'd12, 16'd12, 2'd2},  // R9 evicted line refetched
    '{4'b1110, 16'h0243, 16'd13, 16'd13, 2'd2},  // R9 evicted again
    '{4'b0110, 16'h0085, 16'd14, 16'd9,  2'd0}   // R9 set 1 untouched
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [3:0]        req_attr_i = '0;
  logic              rsp_valid_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic              mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_ack_i = 1'b0;
  logic [DATA_W-1:0] mem_rdata_i = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int acc_cnt = 0;
  int last_ack_cyc = 0;
  int lat_cnt = 0;
  bit done = 1'b0;
  logic [15:0] epoch = '0;
  logic [ADDR_W-1:0] addr_log [8];

  cache_read_dispatch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE), .SETS(8)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_attr_i  (req_attr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );

  always #5 clk_i = ~clk_i;

  initial forever begin
    @(posedge clk_i);
    cyc++;
  end

  // downstream memory model: ack after MEM_LAT cycles, one cycle wide
  initial forever begin
    @(negedge clk_i);
    if (!rst_ni) begin
      mem_ack_i = 1'b0;
      lat_cnt = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      lat_cnt = 0;
    end else if (mem_req_o) begin
      lat_cnt++;
      if (lat_cnt == MEM_LAT) begin
        mem_ack_i = 1'b1;
        mem_rdata_i = {epoch, mem_addr_o};
        if (acc_cnt < 8) addr_log[acc_cnt] = mem_addr_o;
        acc_cnt++;
        last_ack_cyc = cyc;
      end
    end else begin
      lat_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string req);
    int acc_cyc;
    int rsp_cyc;
    int n;
    int exp_acc;
    bit addr_ok;
    logic [ADDR_W-1:0] base;
    @(negedge clk_i);
    epoch = v.ep;
    acc_cnt = 0;
    req_addr_i = v.addr;
    req_attr_i = v.attr;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    acc_cyc = cyc;
    chk(!req_ready_o, "R7", "ready low after accept", 64'(req_ready_o), 64'd0);
    n = 0;
    while (!rsp_valid_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    rsp_cyc = cyc;
    chk(rsp_valid_o, req, "response seen", 64'(rsp_valid_o), 64'd1);
    chk(rsp_data_o == {v.exp_ep, v.addr}, req, "response data",
        64'(rsp_data_o), 64'({v.exp_ep, v.addr}));
    exp_acc = (v.kind == 2'd0) ? 0 : (v.kind == 2'd1) ? 1 : LINE;
    chk(acc_cnt == exp_acc, req, "downstream reads", 64'(acc_cnt), 64'(exp_acc));
    base = {v.addr[ADDR_W-1:2], 2'b00};
    addr_ok = 1'b1;
    for (int i = 0; i < acc_cnt && i < 8; i++) begin
      if (v.kind == 2'd2) begin
        if (addr_log[i] != base + ADDR_W'(i)) addr_ok = 1'b0;
      end else if (addr_log[i] != v.addr) begin
        addr_ok = 1'b0;
      end
    end
    chk(addr_ok, (v.kind == 2'd2) ? "R5" : req, "downstream addresses",
        64'(addr_log[0]), 64'((v.kind == 2'd2) ? base : v.addr));
    if (v.kind == 2'd0)
      chk(rsp_cyc - acc_cyc == 1, "R4", "hit latency", 64'(rsp_cyc - acc_cyc), 64'd1);
    else if (v.kind == 2'd1)
      chk(rsp_cyc - last_ack_cyc == 1, "R8", "uncached latency",
          64'(rsp_cyc - last_ack_cyc), 64'd1);
    else
      chk(rsp_cyc - last_ack_cyc == 2, "R8", "linefill latency",
          64'(rsp_cyc - last_ack_cyc), 64'd2);
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R7", "single response pulse then idle",
        64'({rsp_valid_o, req_ready_o}), 64'b01);
  endtask

  function automatic string req_of(input vec_t v);
    if (v.kind == 2'd0) return "R4";
    if (v.kind == 2'd2) return "R5";
    if (!v.attr[1]) return v.attr[0] ? "R2" : "R1";
    if (v.attr[3:2] == 2'b00) return "R3";
    return "R6";
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(req_ready_o, "R10", "ready after reset", 64'(req_ready_o), 64'd1);
    chk(!rsp_valid_o, "R10", "no response after reset", 64'(rsp_valid_o), 64'd0);
    chk(!mem_req_o, "R10", "no downstream request after reset", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < 14; k++) run_vec(VECS[k], req_of(VECS[k]));

    // R10 reset in the middle of use: lines become invalid
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R10", "state after second reset",
        64'({req_ready_o, rsp_valid_o, mem_req_o}), 64'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // set 1 held 0x84 line; now must refill (R10)
    run_vec('{4'b0110, 16'h0084, 16'd20, 16'd20, 2'd2}, "R10");
    // refilled line then hits (R9 set mapping after refill)
    run_vec('{4'b0110, 16'h0087, 16'd21, 16'd20, 2'd0}, "R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule